// File: doc/BRIEF.md
# Charge-Balance Frequency Modulator

This block is a cycle-accurate digital model of a synchronous voltage-to-frequency converter. It takes an input code that is already digital, either straight binary or two's complement, and turns it into a train of one-cycle strobes on the master clock. The average strobe rate is 5% of the clock rate at the bottom of the input range and 45% at the top, and it varies linearly between those two points. A gain select halves the input span needed to sweep that range. An active-low power-down stops the output.

The modulator is a first-order charge-balance loop, built as a phase accumulator. On every enabled clock it adds an increment equal to `0.05 + 0.4·x` of its modulus, where `x` is the normalised input level. Each overflow emits a strobe. Because the increment is usually not a divisor of the modulus, the spacing between strobes alternates between adjacent whole clock counts, and the long-run mean lands on the fractional target. A settle tracker holds a valid flag low for a parameterised number of cycles after power-up and after any change in the effective input.

A downstream counter that gates on a divided copy of the same clock reads the strobe train as a conversion result. `valid_o` tells that counter when a gate window may begin.

Top module: `charge_balance_vfc`

## Requirements
- R1: The level `s` is the normalised input scaled to 0..2^CODE_W. When `s` = 0 the mean strobe rate is 1/20 of the clock rate. This level is reached with unipolar code 0x0000 and with bipolar code 0x8000.
- R2: The mean strobe rate is `(2^CODE_W + 8·s) / (20·2^CODE_W)` of the clock rate. With `s` = 2^CODE_W this gives 9/20. A bipolar code of 0x7FFF at gain x1 gives a rate just under 9/20.
- R3: In unipolar mode at gain x1 with CODE_W = 16, the rates are fixed at three points: code 0x2000 gives clk/10, code 0x4000 gives clk·3/20, and code 0x8000 gives clk/4.
- R4: At unipolar code 0x4000 and gain x1, every gap between consecutive strobes is 6 or 7 clock periods.
- R5: `pulse_o` is a registered strobe that is high for exactly one clock period. Two strobes never occur on consecutive cycles.
- R6: When `gain2_i` = 1, the level is `2·u − c`, clamped to 0..2^CODE_W. Here `u` is the gain-x1 level and `c` is 0 in unipolar mode and 2^(CODE_W−1) in bipolar mode.
- R7: While `pd_ni` = 0, `pulse_o` and `valid_o` stay 0 from the next clock edge onward, and the accumulator is cleared. After `pd_ni` returns to 1 with unipolar code 0x4000 at gain x1, the first strobe appears on the 7th clock edge.
- R8: `valid_o` is 0 during reset. When the level changes while the block is powered, `valid_o` goes to 0 on the next clock edge. When `pd_ni` returns to 1, `valid_o` is 1 only after SETTLE_CYC further edges pass with no change in the level. The default value of SETTLE_CYC is 2.
- R9: When `bipolar_i` = 1, `code_i` is read as two's complement and has 2^(CODE_W−1) added to it. So code 0x0000 gives clk/4 and code 0xC000 gives clk·3/20 at gain x1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down, active low, synchronous |
| bipolar_i | input | 1 | 1: code is two's complement; 0: straight binary |
| gain2_i | input | 1 | 1: gain x2; 0: gain x1 |
| code_i | input | CODE_W | Input code |
| pulse_o | output | 1 | One-cycle rate strobe |
| valid_o | output | 1 | Output has settled since the last power-up or input change |

## Verification
Some properties are checked by assertions on every clock:
- The accumulator stays below its modulus.
- A strobe is never followed by another strobe on the next cycle.
- The output goes idle one edge after power-down is sampled.
- A change in the effective level drops `valid_o` on the next edge.
- The scaled level never exceeds full scale.

Other properties need the bench's scenarios, because they only show up over hundreds of cycles or at exact edge counts:
- the mean rates at the ends of the range and at the fixed points,
- the 6-or-7 spacing,
- the gain doubling and its clamp,
- the bipolar offset,
- the phase of the first strobe after power-down is released.

// File: rtl/cbv_pkg.sv
package cbv_pkg;
  // rate = (OFS_NUM + SPAN_NUM * s/FS) / RATE_DEN
  localparam int RATE_DEN = 20;
  localparam int OFS_NUM  = 1;
  localparam int SPAN_NUM = 8;

  typedef enum logic {
    RANGE_UNI = 1'b0,
    RANGE_BIP = 1'b1
  } range_mode_e;
endpackage

// File: rtl/cbv_scaler.sv
module cbv_scaler
  import cbv_pkg::*;
#(
  parameter int CODE_W     = 16,
  parameter bit GAIN_X2_EN = 1'b1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              bipolar_i,
  input  logic              gain2_i,
  output logic [CODE_W:0]   level_o
);
  localparam int FS   = 1 << CODE_W;
  localparam int HALF = FS / 2;
  localparam int SW   = CODE_W + 4;
  localparam logic signed [SW-1:0] FS_S   = SW'(FS);
  localparam logic signed [SW-1:0] HALF_S = SW'(HALF);

  range_mode_e     mode;
  logic [CODE_W:0] base;

  assign mode = range_mode_e'(bipolar_i);

  // bipolar: two's complement + half scale == flip msb
  always_comb begin
    base = {1'b0, code_i};
    if (mode == RANGE_BIP) base[CODE_W-1] = ~code_i[CODE_W-1];
  end

  generate
    if (GAIN_X2_EN) begin : g_gain
      logic signed [SW-1:0] ctr;
      logic signed [SW-1:0] dbl;
      always_comb begin
        ctr = (mode == RANGE_BIP) ? HALF_S : '0;
        dbl = $signed({2'b00, base, 1'b0}) - ctr;
        if (!gain2_i)        level_o = base;
        else if (dbl < 0)    level_o = '0;
        else if (dbl > FS_S) level_o = FS_S[CODE_W:0];
        else                 level_o = dbl[CODE_W:0];
      end
    end else begin : g_nogain
      logic unused_gain;
      assign unused_gain = gain2_i;
      assign level_o     = base;
    end
  endgenerate
endmodule

// File: rtl/cbv_phase_accum.sv
module cbv_phase_accum
  import cbv_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [CODE_W:0] level_i,
  output logic            pulse_o
);
  localparam int unsigned FS    = 1 << CODE_W;
  localparam int unsigned MODV  = RATE_DEN * FS;
  localparam int          ACC_W = $clog2(MODV);
  localparam logic [ACC_W:0]   MOD_A = (ACC_W+1)'(MODV);
  localparam logic [ACC_W-1:0] OFS_A = ACC_W'(OFS_NUM * FS);

  logic [ACC_W-1:0] acc_q, inc_w;
  logic [ACC_W:0]   sum_w, nxt_w;
  logic             wrap_w, pulse_q;

  always_comb begin
    inc_w  = OFS_A + ACC_W'(SPAN_NUM * int'(level_i));
    sum_w  = {1'b0, acc_q} + {1'b0, inc_w};
    wrap_w = (sum_w >= MOD_A);
    nxt_w  = wrap_w ? (sum_w - MOD_A) : sum_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!en_i) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= nxt_w[ACC_W-1:0];
      pulse_q <= wrap_w;
    end
  end

  assign pulse_o = pulse_q;

  AST_ACC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, acc_q} < MOD_A); // R2
  AST_STROBE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q); // R5
endmodule

// File: rtl/cbv_settle.sv
module cbv_settle #(
  parameter int CODE_W     = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [CODE_W:0] level_i,
  output logic            valid_o
);
  localparam int SC = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;
  localparam int CW = $clog2(SC + 1);
  localparam logic [CW-1:0] DONE = CW'(SC);

  logic [CW-1:0]   cnt_q;
  logic [CODE_W:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= level_i;
      if (!en_i || level_i != prev_q) cnt_q <= '0;
      else if (cnt_q != DONE)         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = (cnt_q == DONE);

  AST_PD_CLEARS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o); // R8
endmodule

// File: rtl/charge_balance_vfc.sv
module charge_balance_vfc #(
  parameter int CODE_W     = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic              bipolar_i,
  input  logic              gain2_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o,
  output logic              valid_o
);
  localparam logic [CODE_W:0] FULL = (CODE_W+1)'(1 << CODE_W);

  logic [CODE_W:0] level_w;

  cbv_scaler #(.CODE_W(CODE_W), .GAIN_X2_EN(1'b1)) u_scaler (
    .code_i   (code_i),
    .bipolar_i(bipolar_i),
    .gain2_i  (gain2_i),
    .level_o  (level_w)
  );

  cbv_phase_accum #(.CODE_W(CODE_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pd_ni),
    .level_i(level_w),
    .pulse_o(pulse_o)
  );

  cbv_settle #(.CODE_W(CODE_W), .SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pd_ni),
    .level_i(level_w),
    .valid_o(valid_o)
  );

  AST_PD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (!pulse_o && !valid_o)); // R7
  AST_STEP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ni && !$stable(level_w)) |=> !valid_o); // R8
  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_w <= FULL); // R6
endmodule

// File: tb/charge_balance_vfc_bench.sv
module charge_balance_vfc_bench;
  localparam int CODE_W = 16;
  localparam int FS     = 1 << CODE_W;
  localparam int WIN    = 2000;

  logic clk = 1'b0;
  logic rst_ni, pd_ni, bipolar, gain2, pulse, valid;
  logic [CODE_W-1:0] code;

  always #4 clk = ~clk;

  charge_balance_vfc u_charge_balance_vfc (
    .clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni), .bipolar_i(bipolar),
    .gain2_i(gain2), .code_i(code), .pulse_o(pulse), .valid_o(valid)
  );

  typedef struct { string tag; int cycles; int lo; int hi; } exp_t;
  exp_t sb_q[$];
  int   n_run = 0, n_fail = 0, issued = 0, mon_done = 0, b2b = 0;
  bit   finished = 1'b0;

  task automatic chk(string req, int act, int lo, int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // level per R6/R9, rate per R2
  function automatic int level_of(logic [CODE_W-1:0] c, logic b, logic g);
    int u, ctr, v;
    u   = b ? int'($signed(c)) + FS / 2 : int'(c);
    ctr = b ? FS / 2 : 0;
    v   = g ? 2 * u - ctr : u;
    if (v < 0)  v = 0;
    if (v > FS) v = FS;
    return v;
  endfunction

  task automatic set_cfg(logic [CODE_W-1:0] c, logic b, logic g);
    @(negedge clk);
    code = c; bipolar = b; gain2 = g;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (valid) break;
    end
  endtask

  task automatic window(string tag, logic [CODE_W-1:0] c, logic b, logic g);
    longint num, m;
    exp_t   it;
    set_cfg(c, b, g);
    m  = longint'(20) * FS;
    num = longint'(WIN) * (FS + 8 * level_of(c, b, g));
    it.tag = tag; it.cycles = WIN;
    it.lo = int'(num / m); it.hi = int'((num + m - 1) / m);
    sb_q.push_back(it);
    issued++;
    wait (mon_done == issued);
  endtask

  // monitor: pops expected counts and compares against strobes seen
  initial begin
    exp_t it;
    int   n;
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        n  = 0;
        for (int i = 0; i < it.cycles; i++) begin
          @(negedge clk);
          if (pulse) n++;
        end
        chk(it.tag, n, it.lo, it.hi);
        mon_done++;
      end
    end
  end

  initial begin
    bit prev_p;
    prev_p = 1'b0;
    forever begin
      @(negedge clk);
      if (pulse && prev_p) b2b++;
      prev_p = pulse;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int first, gap, bad, seen, v1, v2;
    rst_ni = 1'b0; pd_ni = 1'b1; bipolar = 1'b0; gain2 = 1'b0; code = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset pulse", int'(pulse), 0, 0);
    chk("R8 reset valid", int'(valid), 0, 0);
    rst_ni = 1'b1;

    window("R1 unipolar zero",    16'h0000, 1'b0, 1'b0);
    window("R1 R9 bipolar min",   16'h8000, 1'b1, 1'b0);
    window("R2 bipolar max",      16'h7FFF, 1'b1, 1'b0);
    window("R3 eighth",           16'h2000, 1'b0, 1'b0);
    window("R3 quarter",          16'h4000, 1'b0, 1'b0);
    window("R3 half",             16'h8000, 1'b0, 1'b0);
    window("R9 bipolar zero",     16'h0000, 1'b1, 1'b0);
    window("R9 bipolar negative", 16'hC000, 1'b1, 1'b0);
    window("R6 uni x2",           16'h2000, 1'b0, 1'b1);
    window("R6 bip x2",           16'h2000, 1'b1, 1'b1);
    window("R6 uni x2 clamp hi",  16'hC000, 1'b0, 1'b1);
    window("R6 bip x2 clamp lo",  16'h9000, 1'b1, 1'b1);

    // R4: strobe spacing at quarter scale
    set_cfg(16'h4000, 1'b0, 1'b0);
    bad = 0; seen = 0; gap = 0;
    while (!pulse) @(negedge clk);
    while (seen < 40) begin
      @(negedge clk);
      gap++;
      if (pulse) begin
        if (gap != 6 && gap != 7) bad++;
        seen++; gap = 0;
      end
    end
    chk("R4 gaps outside 6..7", bad, 0, 0);

    // R7: power-down idles output
    @(negedge clk);
    pd_ni = 1'b0;
    @(negedge clk);
    sb_q.push_back('{tag: "R7 strobes in power-down", cycles: 300, lo: 0, hi: 0});
    issued++;
    wait (mon_done == issued);
    chk("R7 valid in power-down", int'(valid), 0, 0);

    // R7/R8: release phase and settling
    pd_ni = 1'b1;
    first = 0; v1 = -1; v2 = -1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) v1 = int'(valid);
      if (k == 2) v2 = int'(valid);
      if (pulse && first == 0) first = k;
    end
    chk("R7 first strobe edge", first, 7, 7);
    chk("R8 valid after 1 edge", v1, 0, 0);
    chk("R8 valid after 2 edges", v2, 1, 1);

    // R8: step change restarts settling
    code = 16'h5000;
    @(negedge clk); v1 = int'(valid);
    @(negedge clk); v2 = int'(valid);
    @(negedge clk);
    chk("R8 step edge 1", v1, 0, 0);
    chk("R8 step edge 2", v2, 0, 0);
    chk("R8 step edge 3", int'(valid), 1, 1);

    chk("R5 back-to-back strobes", b2b, 0, 0);
    finish_run();
  end
endmodule